// File: doc/BRIEF.md
# Resolution-Aware Temperature Conversion Sequencer

This block paces the temperature conversions of a digital thermometer and publishes each result. Out of reset it starts converting on its own, one conversion after another, with no host action. The length of each conversion depends on a 2-bit resolution code: every extra bit of resolution doubles the conversion time. The analog converter is not part of the block. A 12-bit two's-complement sample port stands in for it and is read in the last cycle of every conversion.

On each completion the sample is left-justified into a 16-bit word. The low nibble and every bit below the active resolution are forced to zero. The word is then offered to the alarm comparator through a one-cycle `conv_done` strobe. The same word is also copied into the readable temperature register, unless a bus read is in progress at that moment; in that case the register keeps its old value and the skipped result is dropped. A shutdown request lets the running conversion finish and publish, then parks the sequencer until the request is withdrawn.

Top module: `tseq_conv_sequencer`

## Requirements
- R1: After reset `temp_reg` is 0x0000, `converting` is 1, and the first conversion uses the 9-bit period whatever `res_code` holds.
- R2: A conversion lasts BASE_TICKS << code clock cycles, with code 00/01/10/11 selecting 9/10/11/12 bits. In steady operation, `conv_done` pulses exactly that many cycles apart.
- R3: A result is the 12-bit sample placed in bits 15..4, with the sign in bit 15 and bits 3..0 always zero. For example, sample 0x7D0 gives 0x7D00 and sample 0xC90 gives 0xC900.
- R4: Only the top 9+code bits of a result are kept and the rest read as zero. For example, sample 0xF5E gives 0xF580, 0xF5C0, 0xF5E0 and 0xF5E0 for codes 00 to 11.
- R5: When `shutdown` is high at a completion, that result is still published, `converting` drops and no further completion occurs. Lowering `shutdown` starts a fresh conversion, which completes BASE_TICKS<<code + 1 cycles after the release.
- R6: `conv_done` is a one-cycle pulse, and `cmp_value` carries every completed result while it is high, whether or not a read is in progress.
- R7: If `read_busy` is high in the last cycle of a conversion, `temp_reg` keeps its previous value.
- R8: A result skipped during a read is never applied later. `temp_reg` changes only at a completion that does not overlap a read.
- R9: A change of `res_code` during a conversion does not alter that conversion's period or masking. It takes effect from the next conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_code | input | 2 | Resolution select (00 = 9 bits … 11 = 12 bits) |
| shutdown | input | 1 | Request to enter standby after the current conversion |
| read_busy | input | 1 | High while a bus read of the temperature register is in progress |
| smp_data | input | 12 | Two's-complement sample from the converter model |
| conv_done | output | 1 | One-cycle strobe marking a completed conversion |
| cmp_value | output | 16 | Formatted result for the comparison path, valid with `conv_done` |
| temp_reg | output | 16 | Readable temperature register |
| converting | output | 1 | High while a conversion is running |

## Verification
The bench builds the block with BASE_TICKS set to 8, so conversions last 8, 16, 32 or 64 cycles instead of millions. At that scale every resolution period can be measured edge-exact in a single run. The same setting brings within reach a mid-conversion code change, a shutdown and resume, and a read that overlaps a completion followed by one that does not. The default setting, which models 150 ms at 50 MHz, only changes the counter width.

// File: rtl/tseq_pkg.sv
// Package: shared constants and helpers for the conversion sequencer.
// Assumes: resolution code is 2 bits; the data word is 16 bits wide.
package tseq_pkg;
    localparam int SMP_W  = 12;
    localparam int WORD_W = 16;
    localparam logic [1:0] RES_9BIT = 2'b00;

    // Keep-mask for a result: top 9+code bits kept, the rest cleared.
    function automatic logic [WORD_W-1:0] res_mask(input logic [1:0] code);
        logic [WORD_W-1:0] ones;
        ones = '1;
        return ~(ones >> (5'd9 + {3'b000, code}));
    endfunction
endpackage

// File: rtl/tseq_timer.sv
// Module: conversion timer. Runs conversions back to back, latching the
// resolution code at the start of each one and flagging its last cycle.
// Assumes: BASE_TICKS >= 2; the period for code c is BASE_TICKS << c.
module tseq_timer #(
    parameter int BASE_TICKS = 7_500_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] res_code,
    input  logic       shutdown,
    output logic       active,
    output logic       last,
    output logic [1:0] code_q
);
    localparam int CNT_W = $clog2(BASE_TICKS * 8 + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Period of the running conversion in cycles.
    assign limit = CNT_W'(BASE_TICKS) << code_q;
    // Final cycle of the running conversion.
    assign last  = active && (cnt == limit - CNT_W'(1));

    // Count cycles, roll over into the next conversion or into standby.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b1;
            cnt    <= '0;
            code_q <= tseq_pkg::RES_9BIT;
        end else if (active) begin
            if (last) begin
                cnt    <= '0;
                code_q <= res_code;
                active <= !shutdown;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end else if (!shutdown) begin
            active <= 1'b1;
            cnt    <= '0;
            code_q <= res_code;
        end
    end
endmodule

// File: rtl/tseq_format.sv
// Module: result formatter. Left-justifies a 12-bit sample into 16 bits
// and clears every bit below the selected resolution.
// Assumes: purely combinational; code is the code of the finishing conversion.
module tseq_format (
    input  logic [tseq_pkg::SMP_W-1:0]  smp,
    input  logic [1:0]                  code,
    output logic [tseq_pkg::WORD_W-1:0] word
);
    localparam int PAD_W = tseq_pkg::WORD_W - tseq_pkg::SMP_W;

    // Justify, then apply the resolution keep-mask.
    always_comb begin
        word = {smp, {PAD_W{1'b0}}} & tseq_pkg::res_mask(code);
    end
endmodule

// File: rtl/tseq_publish.sv
// Module: result publisher. Strobes each result to the comparison path
// and updates the readable register unless a read is in progress.
// Assumes: 'last' is a single-cycle pulse from the timer.
module tseq_publish (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        last,
    input  logic                        read_busy,
    input  logic [tseq_pkg::WORD_W-1:0] word,
    output logic                        conv_done,
    output logic [tseq_pkg::WORD_W-1:0] cmp_value,
    output logic [tseq_pkg::WORD_W-1:0] temp_reg
);
    // Comparison path: every completion is forwarded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_done <= 1'b0;
            cmp_value <= '0;
        end else begin
            conv_done <= last;
            if (last) cmp_value <= word;
        end
    end

    // Readable register: skip the completion that overlaps a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_reg <= '0;
        end else if (last && !read_busy) begin
            temp_reg <= word;
        end
    end
endmodule

// File: rtl/tseq_conv_sequencer.sv
// Module: top of the conversion sequencer. Wires the timer, formatter and
// publisher; the sample port stands in for the analog converter.
// Assumes: smp_data is valid during the last cycle of each conversion.
module tseq_conv_sequencer #(
    parameter int BASE_TICKS = 7_500_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  res_code,
    input  logic        shutdown,
    input  logic        read_busy,
    input  logic [11:0] smp_data,
    output logic        conv_done,
    output logic [15:0] cmp_value,
    output logic [15:0] temp_reg,
    output logic        converting
);
    logic       last;
    logic [1:0] code_q;
    logic [15:0] word;

    tseq_timer #(.BASE_TICKS(BASE_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .res_code(res_code), .shutdown(shutdown),
        .active(converting), .last(last), .code_q(code_q)
    );

    tseq_format u_format (
        .smp(smp_data), .code(code_q), .word(word)
    );

    tseq_publish u_publish (
        .clk(clk), .rst_n(rst_n), .last(last), .read_busy(read_busy),
        .word(word), .conv_done(conv_done), .cmp_value(cmp_value),
        .temp_reg(temp_reg)
    );
endmodule

// File: rtl/tseq_conv_sequencer_chk.sv
// Module: property checker for the conversion sequencer, bound to the top.
// Assumes: observes top-level ports only.
module tseq_conv_sequencer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        shutdown,
    input logic        read_busy,
    input logic        conv_done,
    input logic [15:0] cmp_value,
    input logic [15:0] temp_reg,
    input logic        converting
);
    AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> (cmp_value[3:0] == 4'h0 && temp_reg[3:0] == 4'h0)); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done); // R6
    AST_STANDBY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(converting) |-> conv_done); // R5
    AST_STANDBY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!converting && shutdown) |=> !converting); // R5
    AST_REG_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |-> $stable(temp_reg)); // R8
    AST_REG_FOLLOWS_FREE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !$past(read_busy)) |-> (temp_reg == cmp_value)); // R7
endmodule

bind tseq_conv_sequencer tseq_conv_sequencer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .read_busy(read_busy),
    .conv_done(conv_done), .cmp_value(cmp_value), .temp_reg(temp_reg),
    .converting(converting)
);

// File: tb/tseq_conv_sequencer_tb.sv
// Bench: directed scenarios for the conversion sequencer, one task each.
module tseq_conv_sequencer_tb;
    localparam int BASE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  res_code = 2'b00;
    logic        shutdown = 1'b0;
    logic        read_busy = 1'b0;
    logic [11:0] smp_data = 12'h000;
    logic        conv_done;
    logic [15:0] cmp_value;
    logic [15:0] temp_reg;
    logic        converting;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk; // 50 MHz

    tseq_conv_sequencer #(.BASE_TICKS(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .res_code(res_code), .shutdown(shutdown),
        .read_busy(read_busy), .smp_data(smp_data), .conv_done(conv_done),
        .cmp_value(cmp_value), .temp_reg(temp_reg), .converting(converting)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Count falling edges until conv_done is seen high (bounded).
    task automatic wait_done(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!conv_done && n < 1000);
    endtask

    task automatic t_reset;
        int n;
        res_code = 2'b11;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 temp_reg after reset", temp_reg, 16'h0000);
        check("R1 converting after reset", converting, 1);
        wait_done(n);
        check("R1 first period is 9-bit", n, BASE);
        wait_done(n);
        check("R2 period code 11", n, BASE << 3);
    endtask

    task automatic t_periods;
        int n;
        for (int c = 0; c < 4; c++) begin
            res_code = c[1:0];
            wait_done(n);
            wait_done(n);
            check($sformatf("R2 period code %0d", c), n, BASE << c);
        end
    endtask

    task automatic t_format;
        int n;
        logic [11:0] s [4] = '{12'h7D0, 12'h191, 12'hFF8, 12'hC90};
        logic [15:0] e [4] = '{16'h7D00, 16'h1910, 16'hFF80, 16'hC900};
        res_code = 2'b11;
        wait_done(n);
        for (int i = 0; i < 4; i++) begin
            smp_data = s[i];
            wait_done(n);
            check("R3 cmp_value justify", cmp_value, e[i]);
            check("R3 temp_reg justify", temp_reg, e[i]);
        end
    endtask

    task automatic t_mask;
        int n;
        logic [15:0] e [4] = '{16'hF580, 16'hF5C0, 16'hF5E0, 16'hF5E0};
        smp_data = 12'hF5E;
        for (int c = 0; c < 4; c++) begin
            res_code = c[1:0];
            wait_done(n);
            wait_done(n);
            check($sformatf("R4 mask code %0d", c), cmp_value, e[c]);
        end
        smp_data = 12'h191;
        res_code = 2'b00;
        wait_done(n);
        wait_done(n);
        check("R4 9-bit 25.0625", cmp_value, 16'h1900);
    endtask

    task automatic t_res_change;
        int n;
        res_code = 2'b00;
        wait_done(n);
        wait_done(n);
        repeat (2) @(negedge clk);
        res_code = 2'b10;
        smp_data = 12'hF5E;
        wait_done(n);
        check("R9 running period unchanged", n, BASE - 2);
        check("R9 running mask unchanged", cmp_value, 16'hF580);
        wait_done(n);
        check("R9 next period uses new code", n, BASE << 2);
        check("R9 next mask uses new code", cmp_value, 16'hF5E0);
    endtask

    task automatic t_read;
        int n;
        res_code = 2'b11;
        smp_data = 12'h0A2;
        wait_done(n);
        wait_done(n);
        check("R7 baseline published", temp_reg, 16'h0A20);
        read_busy = 1'b1;
        smp_data = 12'h191;
        wait_done(n);
        check("R6 cmp_value during read", cmp_value, 16'h1910);
        check("R7 temp_reg held during read", temp_reg, 16'h0A20);
        @(negedge clk);
        check("R6 done is one cycle", conv_done, 0);
        read_busy = 1'b0;
        smp_data = 12'hC90;
        repeat (5) @(negedge clk);
        check("R8 skipped result not applied", temp_reg, 16'h0A20);
        wait_done(n);
        check("R8 next free completion applied", temp_reg, 16'hC900);
    endtask

    task automatic t_shutdown;
        int n;
        bit seen;
        res_code = 2'b00;
        wait_done(n);
        repeat (3) @(negedge clk);
        shutdown = 1'b1;
        smp_data = 12'h7D0;
        wait_done(n);
        check("R5 running conversion completes", n, BASE - 3);
        check("R5 result stored before standby", temp_reg, 16'h7D00);
        check("R5 converting low in standby", converting, 0);
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (conv_done) seen = 1;
        end
        check("R5 no completion in standby", seen, 0);
        shutdown = 1'b0;
        wait_done(n);
        check("R5 resume period", n, BASE + 1);
    endtask

    initial begin
        #(20 * 150_000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_periods();
        t_format();
        t_mask();
        t_res_change();
        t_read();
        t_shutdown();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule